// File: doc/BRIEF.md
# Two-Road Crossing Light Controller

This block gives the right of way to one of two crossing roads at a time, A or B. It is a Moore state machine. Each road has a presence sensor and a lamp output. A road that has the green keeps it for as long as its sensor reports waiting traffic. When its sensor drops, the lamp turns yellow for exactly one clock, then the other road gets the green. The clock period is meant to be the yellow interval, which is a few seconds. The block therefore runs from a slow, already divided clock.

The lamps are decoded from the current state alone, so sensor changes between clock edges never reach the outputs directly. A parameter chooses how the four phases are stored: a two-bit binary code or a four-bit one-hot code. Both choices give the same lamp sequence. With one-hot storage, a corrupted register value shows red on both roads for that cycle, and the machine returns to the start phase on the next edge.

Top module: `traffic_xing_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the machine enters the start phase: `lamp_a` green and `lamp_b` red from that edge on.
- R2: In the phase where A is green, a rising edge with `sense_a` high keeps A green and B red, whatever `sense_b` is.
- R3: In the phase where A is green, a rising edge with `sense_a` low gives A yellow and B red. The next edge always gives A red and B green, whatever the sensors are, so yellow lasts exactly one clock.
- R4: In the phase where B is green, a rising edge with `sense_b` high keeps B green and A red, whatever `sense_a` is.
- R5: In the phase where B is green, a rising edge with `sense_b` low gives B yellow and A red. The next edge always returns to A green and B red.
- R6: The lamps change only at rising clock edges. A sensor change between edges has no effect on the outputs until the next edge.
- R7: Lamp codes are 2'b00 green, 2'b01 yellow and 2'b10 red. The code 2'b11 never appears on either lamp.
- R8: In every cycle at least one of the two lamps is red.
- R9: The binary setting (`ONE_HOT` = 0) and the one-hot setting (`ONE_HOT` = 1) produce identical lamp sequences for the same inputs.
- R10: With one-hot storage, a state value that does not have exactly one bit set drives both lamps red in that cycle. The next rising edge puts the machine in the start phase (A green, B red), whatever the sensors are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock; one period is the yellow interval |
| rst | input | 1 | Synchronous active-high reset |
| sense_a | input | 1 | High while traffic waits on road A |
| sense_b | input | 1 | High while traffic waits on road B |
| lamp_a | output | 2 | Lamp code for road A (00 green, 01 yellow, 10 red) |
| lamp_b | output | 2 | Lamp code for road B (00 green, 01 yellow, 10 red) |

## Verification
The phase assertions assume that the state register holds a legal code whenever they start and finish. They are therefore switched off during reset and during any cycle in which the one-hot register is corrupt. The recovery check covers that cycle on its own. The sensor inputs are assumed to be stable around the rising edge. The stimulus therefore changes them only at the falling edge. The one exception is a deliberate toggle in mid-cycle, which changes the sensors only between edges and puts them back before the next edge. Corrupt codes are injected only into the one-hot instance, and only for a window that ends before the next rising edge. Both instances are reset afterwards, so every later comparison starts from a known phase.

// File: rtl/xing_pkg.sv
`timescale 1ns/1ps
package xing_pkg;

  typedef enum logic [1:0] {
    LAMP_GREEN  = 2'b00,
    LAMP_YELLOW = 2'b01,
    LAMP_RED    = 2'b10
  } lamp_t;

  typedef enum logic [1:0] {
    PH_A_GO   = 2'd0,
    PH_A_WARN = 2'd1,
    PH_B_GO   = 2'd2,
    PH_B_WARN = 2'd3
  } phase_t;

  localparam int NUM_PHASES = 4;

  // Phase successor: green holds on sensor level, warning lasts one step.
  function automatic phase_t phase_step(phase_t cur, logic a_busy, logic b_busy);
    phase_t nxt;
    case (cur)
      PH_A_GO:   nxt = a_busy ? PH_A_GO : PH_A_WARN;
      PH_A_WARN: nxt = PH_B_GO;
      PH_B_GO:   nxt = b_busy ? PH_B_GO : PH_B_WARN;
      PH_B_WARN: nxt = PH_A_GO;
      default:   nxt = PH_A_GO;
    endcase
    return nxt;
  endfunction

  function automatic lamp_t lamp_of_a(phase_t p);
    lamp_t l;
    case (p)
      PH_A_GO:   l = LAMP_GREEN;
      PH_A_WARN: l = LAMP_YELLOW;
      default:   l = LAMP_RED;
    endcase
    return l;
  endfunction

  function automatic lamp_t lamp_of_b(phase_t p);
    lamp_t l;
    case (p)
      PH_B_GO:   l = LAMP_GREEN;
      PH_B_WARN: l = LAMP_YELLOW;
      default:   l = LAMP_RED;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/xing_next.sv
`timescale 1ns/1ps
module xing_next
  import xing_pkg::*;
(
  input  phase_t cur,
  input  logic   legal,
  input  logic   sense_a,
  input  logic   sense_b,
  output phase_t nxt,
  output logic   recover
);

  assign recover = !legal;

  always_comb begin
    if (recover) nxt = PH_A_GO;
    else         nxt = phase_step(cur, sense_a, sense_b);
  end

endmodule

// File: rtl/xing_state_reg.sv
`timescale 1ns/1ps
module xing_state_reg
  import xing_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_t nxt,
  output phase_t cur,
  output logic   legal
);

  localparam int W = ONE_HOT ? NUM_PHASES : $clog2(NUM_PHASES);

  logic [W-1:0] state_q;

  generate
    if (ONE_HOT) begin : g_onehot
      always_ff @(posedge clk) begin
        if (rst) state_q <= W'(1);
        else     state_q <= W'(1) << nxt;
      end

      always_comb begin
        cur = PH_A_GO;
        for (int i = 0; i < NUM_PHASES; i++) begin
          if (state_q[i]) cur = phase_t'(2'(i));
        end
        legal = $onehot(state_q);
      end
    end else begin : g_binary
      always_ff @(posedge clk) begin
        if (rst) state_q <= W'(PH_A_GO);
        else     state_q <= W'(nxt);
      end

      always_comb begin
        cur   = phase_t'(state_q);
        legal = 1'b1;
      end
    end
  endgenerate

  AST_RECOVER_START: assert property (@(posedge clk) disable iff (rst)
    !legal |=> (legal && cur == PH_A_GO)); // R10

endmodule

// File: rtl/xing_lamp_decode.sv
`timescale 1ns/1ps
module xing_lamp_decode
  import xing_pkg::*;
(
  input  phase_t cur,
  input  logic   legal,
  output lamp_t  la,
  output lamp_t  lb
);

  always_comb begin
    if (legal) begin
      la = lamp_of_a(cur);
      lb = lamp_of_b(cur);
    end else begin
      la = LAMP_RED;
      lb = LAMP_RED;
    end
  end

endmodule

// File: rtl/traffic_xing_ctrl.sv
`timescale 1ns/1ps
module traffic_xing_ctrl
  import xing_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sense_a,
  input  logic       sense_b,
  output logic [1:0] lamp_a,
  output logic [1:0] lamp_b
);

  phase_t cur_ph;
  phase_t nxt_ph;
  logic   st_legal;
  logic   st_recover;
  lamp_t  la_w;
  lamp_t  lb_w;

  xing_next u_next (
    .cur     (cur_ph),
    .legal   (st_legal),
    .sense_a (sense_a),
    .sense_b (sense_b),
    .nxt     (nxt_ph),
    .recover (st_recover)
  );

  xing_state_reg #(.ONE_HOT(ONE_HOT)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .nxt   (nxt_ph),
    .cur   (cur_ph),
    .legal (st_legal)
  );

  xing_lamp_decode u_dec (
    .cur   (cur_ph),
    .legal (st_legal),
    .la    (la_w),
    .lb    (lb_w)
  );

  assign lamp_a = la_w;
  assign lamp_b = lb_w;

  // Named events for the phase assertions
  logic a_green, b_green, a_yellow, b_yellow;
  assign a_green  = (lamp_a == LAMP_GREEN);
  assign b_green  = (lamp_b == LAMP_GREEN);
  assign a_yellow = (lamp_a == LAMP_YELLOW);
  assign b_yellow = (lamp_b == LAMP_YELLOW);

  AST_NO_CODE3: assert property (@(posedge clk) disable iff (rst)
    (lamp_a != 2'b11) && (lamp_b != 2'b11)); // R7
  AST_ONE_ROAD: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == LAMP_RED) || (lamp_b == LAMP_RED)); // R8
  AST_HOLD_A: assert property (@(posedge clk) disable iff (rst || !st_legal)
    (a_green && sense_a) |=> (a_green && lamp_b == LAMP_RED)); // R2
  AST_WARN_A: assert property (@(posedge clk) disable iff (rst || !st_legal)
    (a_green && !sense_a) |=> (a_yellow && lamp_b == LAMP_RED)); // R3
  AST_HANDOVER_B: assert property (@(posedge clk) disable iff (rst || !st_legal)
    a_yellow |=> (lamp_a == LAMP_RED && b_green)); // R3
  AST_HOLD_B: assert property (@(posedge clk) disable iff (rst || !st_legal)
    (b_green && sense_b) |=> (b_green && lamp_a == LAMP_RED)); // R4
  AST_WARN_B: assert property (@(posedge clk) disable iff (rst || !st_legal)
    (b_green && !sense_b) |=> (b_yellow && lamp_a == LAMP_RED)); // R5
  AST_HANDOVER_A: assert property (@(posedge clk) disable iff (rst || !st_legal)
    b_yellow |=> (a_green && lamp_b == LAMP_RED)); // R5

endmodule

// File: tb/sim_traffic_xing_ctrl.sv
`timescale 1ns/1ps
module sim_traffic_xing_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sense_a = 1'b0;
  logic sense_b = 1'b0;
  logic [1:0] la0, lb0, la1, lb1;

  int n_chk = 0;
  int n_fail = 0;
  int ref_ph = 0;

  localparam logic [1:0] GRN = 2'b00;
  localparam logic [1:0] YEL = 2'b01;
  localparam logic [1:0] RED = 2'b10;

  always #2 clk = ~clk;

  traffic_xing_ctrl #(.ONE_HOT(1'b1)) u0 (
    .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
    .lamp_a(la0), .lamp_b(lb0));

  traffic_xing_ctrl #(.ONE_HOT(1'b0)) u1 (
    .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
    .lamp_a(la1), .lamp_b(lb1));

  // Reference: phase 0 A green, 1 A yellow, 2 B green, 3 B yellow
  function automatic int ref_next(int p, logic ta, logic tb);
    if (p == 0) return ta ? 0 : 1;
    if (p == 2) return tb ? 2 : 3;
    return (p + 1) % 4;
  endfunction

  function automatic logic [1:0] exp_a(int p);
    return (p == 0) ? GRN : (p == 1) ? YEL : RED;
  endfunction

  function automatic logic [1:0] exp_b(int p);
    return (p == 2) ? GRN : (p == 3) ? YEL : RED;
  endfunction

  task automatic chk(input logic [1:0] got, input logic [1:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic ta, input logic tb, input logic r);
    int prev;
    string tag;
    @(negedge clk);
    sense_a = ta; sense_b = tb; rst = r;
    @(posedge clk);
    prev = ref_ph;
    ref_ph = r ? 0 : ref_next(ref_ph, ta, tb);
    #1;
    if (r)              tag = "R1";
    else if (prev == 0) tag = ta ? "R2" : "R3";
    else if (prev == 1) tag = "R3";
    else if (prev == 2) tag = tb ? "R4" : "R5";
    else                tag = "R5";
    chk(la0, exp_a(ref_ph), tag);
    chk(lb0, exp_b(ref_ph), tag);
    chk(la1, exp_a(ref_ph), "R9");
    chk(lb1, exp_b(ref_ph), "R9");
    chk({1'b0, (la0 == 2'b11) || (lb0 == 2'b11) || (la1 == 2'b11) || (lb1 == 2'b11)}, 2'b00, "R7");
    chk({1'b0, (la0 != RED) && (lb0 != RED)}, 2'b00, "R8");
  endtask

  // Mid-cycle sensor toggle: outputs must hold until the next edge
  task automatic toggle_between_edges(input logic [1:0] hold_a, input logic [1:0] hold_b);
    @(negedge clk);
    sense_a = ~sense_a; sense_b = ~sense_b;
    #0.5;
    chk(la0, hold_a, "R6"); chk(lb0, hold_b, "R6");
    chk(la1, hold_a, "R6"); chk(lb1, hold_b, "R6");
    sense_a = ~sense_a; sense_b = ~sense_b;
    #0.5;
    chk(la0, hold_a, "R6"); chk(lb0, hold_b, "R6");
  endtask

  task automatic inject(input logic [3:0] bad);
    @(negedge clk);
    sense_a = 1'b0; sense_b = 1'b1;
    force u0.u_reg.state_q = bad;
    #0.5;
    chk(la0, RED, "R10"); chk(lb0, RED, "R10");
    release u0.u_reg.state_q;
    @(posedge clk);
    #1;
    chk(la0, GRN, "R10"); chk(lb0, RED, "R10");
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset state
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1);

    // Directed walk through all four phases
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);

    // Exhaustive: every phase against every sensor pair
    for (int ph = 0; ph < 4; ph++) begin
      for (int c = 0; c < 4; c++) begin
        step(1'b0, 1'b0, 1'b1);
        for (int k = 0; k < ph; k++) step(1'b0, 1'b0, 1'b0);
        step(c[0], c[1], 1'b0);
        step(c[1], c[0], 1'b0);
      end
    end

    // R6: mid-cycle changes in A green and in B green
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    toggle_between_edges(GRN, RED);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    toggle_between_edges(RED, GRN);
    step(1'b0, 1'b1, 1'b0);

    // Pseudo-random stream with occasional reset
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[1] | lfsr[5], lfsr[9:4] == 6'd0);
    end

    // R10: corrupt one-hot codes, from B green
    foreach (bad_codes[i]) begin
      step(1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      inject(bad_codes[i]);
      step(1'b0, 1'b0, 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [3:0] bad_codes [4] = '{4'b0000, 4'b0110, 4'b1111, 4'b1001};

endmodule